// File: doc/BRIEF.md
# Exception Syndrome Register Generator

This block builds and holds the syndrome word that tells an interrupt handler why a program, alignment, data-storage or data-TLB interrupt was taken. When the pipeline takes one of these exceptions it pulses a take strobe with a two-bit type code, together with the decoded class flags of the faulting instruction and the current machine-state bits. The block then rewrites the whole 32-bit syndrome register in a single cycle. Only the bits that apply to the taken type may be set.

Two combinational request outputs come from the same inputs. The first reports a cache-lock violation: a data- or instruction-cache lock or unlock operation issued in user mode while user cache locking is disabled. Such a violation must be delivered as a data-storage interrupt. The second reports that the vector unit is unavailable. It is raised when the vector-available state bit is clear and the instruction touches the upper half of a 64-bit register. When the `GATE_SCALAR_FP` parameter is 1, scalar single-precision float instructions raise it as well.

Software can overwrite the register through a simple write port. Bits that carry no syndrome meaning always read as zero.

Top module: `exc_syndrome_gen`

## Requirements
- R1: After reset the syndrome output `syn_o` is all zero.
- R2: On a take with type 0 (program), register bit 27 equals the illegal flag, bit 26 equals the privileged flag and bit 25 equals the trap flag. Every other bit is zero.
- R3: On a take with type 1 (alignment), type 2 (data storage) or type 3 (data TLB), register bit 23 equals the store flag. On a program take, bit 23 is zero.
- R4: On a type-2 take, register bit 21 is set exactly when the data-cache-lock flag is set, user mode is 1 and user lock enable is 0. On every other type it is zero.
- R5: On a type-2 take, register bit 20 is set exactly when the instruction-cache-lock flag is set, user mode is 1 and user lock enable is 0. On every other type it is zero.
- R6: Register bits 31..28, 24, 22, 19, 18 and 17..0 are always zero, including after a software write of all ones.
- R7: Each take replaces the whole word, so bits from an earlier syndrome do not survive. A take in the same cycle as a software write wins.
- R8: A software write with no take loads the word masked to bits 27, 26, 25, 23, 21 and 20. In a cycle with neither a take nor a write, the register holds its value.
- R9: `dsi_lock_o` is 1 in the same cycle as the inputs when (data-cache-lock or instruction-cache-lock) and user mode and not user lock enable. Otherwise it is 0.
- R10: `vec_unavail_o` is 1 in the same cycle when vector-available is 0 and the upper-half access flag is set. With vector-available at 1 it is 0.
- R11: With `GATE_SCALAR_FP` = 1 (default), a scalar float flag with vector-available at 0 also raises `vec_unavail_o`. With `GATE_SCALAR_FP` = 0 it does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Exception taken this cycle |
| itype_i | input | 2 | 0 program, 1 alignment, 2 data storage, 3 data TLB |
| is_illegal_i | input | 1 | Illegal instruction |
| is_priv_i | input | 1 | Privileged instruction in user mode |
| is_trap_i | input | 1 | Trap instruction |
| is_store_i | input | 1 | Store operation |
| is_dlock_i | input | 1 | Data-cache lock/unlock operation |
| is_ilock_i | input | 1 | Instruction-cache lock/unlock operation |
| vec_hi_i | input | 1 | Access to upper half of a 64-bit register |
| scalar_fp_i | input | 1 | Scalar single-precision float operation |
| msr_user_i | input | 1 | Problem (user) mode |
| msr_ulock_en_i | input | 1 | User cache locking enabled |
| msr_vec_avail_i | input | 1 | Vector unit available |
| csr_we_i | input | 1 | Software write strobe |
| csr_wdata_i | input | 32 | Software write data |
| syn_o | output | 32 | Registered syndrome word |
| dsi_lock_o | output | 1 | Cache-lock violation needs a data-storage interrupt |
| vec_unavail_o | output | 1 | Vector-unit-unavailable interrupt request |

## Verification
A wrong syndrome value shows on `syn_o` one cycle after the take or write that produced it. It stays visible until the next take or write, so a missing clear or a stray reserved bit appears in the very next compare. The two request outputs are combinational, so a wrong gating term shows in the same cycle as the stimulus. The bench drives each lock flag and each availability case with the other conditions both true and false.

// File: rtl/exc_syn_pkg.sv
package exc_syn_pkg;
    localparam int SYN_W = 32;

    typedef enum logic [1:0] {
        IT_PROGRAM = 2'd0,
        IT_ALIGN   = 2'd1,
        IT_DSTORE  = 2'd2,
        IT_DTLB    = 2'd3
    } itype_e;

    // register bit positions (architectural bit b maps to 63-b)
    localparam int B_ILLEGAL = 27;
    localparam int B_PRIV    = 26;
    localparam int B_TRAP    = 25;
    localparam int B_STORE   = 23;
    localparam int B_DLOCK   = 21;
    localparam int B_ILOCK   = 20;

    localparam logic [SYN_W-1:0] DEF_MASK =
        (SYN_W'(1) << B_ILLEGAL) | (SYN_W'(1) << B_PRIV) | (SYN_W'(1) << B_TRAP) |
        (SYN_W'(1) << B_STORE)   | (SYN_W'(1) << B_DLOCK) | (SYN_W'(1) << B_ILOCK);

    typedef struct packed {
        logic [SYN_W-1:0] syn;
    } syn_state_t;
endpackage

// File: rtl/exc_lock_check.sv
module exc_lock_check (
    input  logic is_dlock_i,
    input  logic is_ilock_i,
    input  logic msr_user_i,
    input  logic msr_ulock_en_i,
    output logic dlock_viol_o,
    output logic ilock_viol_o
);
    logic user_locked_out;

    always_comb begin
        user_locked_out = msr_user_i & ~msr_ulock_en_i;
        dlock_viol_o    = is_dlock_i & user_locked_out;
        ilock_viol_o    = is_ilock_i & user_locked_out;
    end

    always_comb begin
        // R4
        dlock_viol_user_chk: assert (!dlock_viol_o || (msr_user_i && !msr_ulock_en_i));
    end
endmodule

// File: rtl/exc_vec_gate.sv
module exc_vec_gate #(
    parameter bit GATE_SCALAR_FP = 1'b1
) (
    input  logic vec_hi_i,
    input  logic scalar_fp_i,
    input  logic msr_vec_avail_i,
    output logic vec_unavail_o
);
    logic trigger;

    generate
        if (GATE_SCALAR_FP) begin : g_with_scalar
            always_comb trigger = vec_hi_i | scalar_fp_i;
        end else begin : g_vec_only
            always_comb trigger = vec_hi_i;
        end
    endgenerate

    always_comb vec_unavail_o = trigger & ~msr_vec_avail_i;

    always_comb begin
        // R10
        vec_avail_blocks_chk: assert (!(vec_unavail_o && msr_vec_avail_i));
    end
endmodule

// File: rtl/exc_syn_builder.sv
module exc_syn_builder
    import exc_syn_pkg::*;
(
    input  logic [1:0]       itype_i,
    input  logic             is_illegal_i,
    input  logic             is_priv_i,
    input  logic             is_trap_i,
    input  logic             is_store_i,
    input  logic             dlock_viol_i,
    input  logic             ilock_viol_i,
    output logic [SYN_W-1:0] word_o
);
    itype_e ty;

    always_comb begin
        ty     = itype_e'(itype_i);
        word_o = '0;
        case (ty)
            IT_PROGRAM: begin
                word_o[B_ILLEGAL] = is_illegal_i;
                word_o[B_PRIV]    = is_priv_i;
                word_o[B_TRAP]    = is_trap_i;
            end
            IT_DSTORE: begin
                word_o[B_STORE] = is_store_i;
                word_o[B_DLOCK] = dlock_viol_i;
                word_o[B_ILOCK] = ilock_viol_i;
            end
            default: begin
                word_o[B_STORE] = is_store_i;
            end
        endcase
    end
endmodule

// File: rtl/exc_syndrome_gen.sv
module exc_syndrome_gen
    import exc_syn_pkg::*;
#(
    parameter bit GATE_SCALAR_FP = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take_i,
    input  logic [1:0]  itype_i,
    input  logic        is_illegal_i,
    input  logic        is_priv_i,
    input  logic        is_trap_i,
    input  logic        is_store_i,
    input  logic        is_dlock_i,
    input  logic        is_ilock_i,
    input  logic        vec_hi_i,
    input  logic        scalar_fp_i,
    input  logic        msr_user_i,
    input  logic        msr_ulock_en_i,
    input  logic        msr_vec_avail_i,
    input  logic        csr_we_i,
    input  logic [31:0] csr_wdata_i,
    output logic [31:0] syn_o,
    output logic        dsi_lock_o,
    output logic        vec_unavail_o
);
    syn_state_t       st_d, st_q;
    logic             dlock_viol, ilock_viol;
    logic [SYN_W-1:0] take_word;

    exc_lock_check u_lock (
        .is_dlock_i     (is_dlock_i),
        .is_ilock_i     (is_ilock_i),
        .msr_user_i     (msr_user_i),
        .msr_ulock_en_i (msr_ulock_en_i),
        .dlock_viol_o   (dlock_viol),
        .ilock_viol_o   (ilock_viol)
    );

    exc_vec_gate #(.GATE_SCALAR_FP(GATE_SCALAR_FP)) u_vec (
        .vec_hi_i        (vec_hi_i),
        .scalar_fp_i     (scalar_fp_i),
        .msr_vec_avail_i (msr_vec_avail_i),
        .vec_unavail_o   (vec_unavail_o)
    );

    exc_syn_builder u_build (
        .itype_i      (itype_i),
        .is_illegal_i (is_illegal_i),
        .is_priv_i    (is_priv_i),
        .is_trap_i    (is_trap_i),
        .is_store_i   (is_store_i),
        .dlock_viol_i (dlock_viol),
        .ilock_viol_i (ilock_viol),
        .word_o       (take_word)
    );

    always_comb begin
        st_d = st_q;
        if (take_i) begin
            st_d.syn = take_word;
        end else if (csr_we_i) begin
            st_d.syn = csr_wdata_i & DEF_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign syn_o      = st_q.syn;
    assign dsi_lock_o = dlock_viol | ilock_viol;

    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_o & ~DEF_MASK) == '0);

    // R2
    prog_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && itype_i == IT_PROGRAM) |=> (syn_o[B_STORE] == 1'b0 && syn_o[B_DLOCK] == 1'b0));

    // R4
    lock_only_dsi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && itype_i != IT_DSTORE) |=> (syn_o[B_DLOCK] == 1'b0 && syn_o[B_ILOCK] == 1'b0));

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_i && !csr_we_i) |=> $stable(syn_o));

    // R9
    lock_req_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsi_lock_o |-> (msr_user_i && !msr_ulock_en_i));
endmodule

// File: tb/exc_syndrome_gen_bench.sv
module exc_syndrome_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take_i = 0;
    logic [1:0]  itype_i = 0;
    logic        is_illegal_i = 0, is_priv_i = 0, is_trap_i = 0, is_store_i = 0;
    logic        is_dlock_i = 0, is_ilock_i = 0, vec_hi_i = 0, scalar_fp_i = 0;
    logic        msr_user_i = 0, msr_ulock_en_i = 0, msr_vec_avail_i = 1;
    logic        csr_we_i = 0;
    logic [31:0] csr_wdata_i = 0;
    logic [31:0] syn_o;
    logic        dsi_lock_o, vec_unavail_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] model = '0;
    logic [31:0] exp_q[$];
    bit done = 0;

    localparam logic [31:0] MASK = 32'h0EB0_0000; // bits 27,26,25,23,21,20

    always #10 clk = ~clk; // 50 MHz

    exc_syndrome_gen u_exc_syndrome_gen (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops one expected word per driven cycle
    always @(posedge clk) begin
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            e = exp_q.pop_front();
            #2 check("R2/R3/R4/R5/R6/R7/R8 syndrome", syn_o, e);
        end
    end

    task automatic drive(input string req, input bit tk, input logic [1:0] ty,
                         input logic [7:0] fl, input logic [2:0] msr,
                         input bit we, input logic [31:0] wd);
        logic [31:0] w;
        bit viol;
        @(negedge clk);
        take_i = tk; itype_i = ty; csr_we_i = we; csr_wdata_i = wd;
        {is_illegal_i, is_priv_i, is_trap_i, is_store_i,
         is_dlock_i, is_ilock_i, vec_hi_i, scalar_fp_i} = fl;
        {msr_user_i, msr_ulock_en_i, msr_vec_avail_i} = msr;
        viol = msr[2] & ~msr[1];
        w = '0;
        if (tk) begin
            if (ty == 2'd0) begin
                w[27] = fl[7]; w[26] = fl[6]; w[25] = fl[5];
            end else begin
                w[23] = fl[4];
                if (ty == 2'd2) begin
                    w[21] = fl[3] & viol; w[20] = fl[2] & viol;
                end
            end
            model = w;
        end else if (we) begin
            model = wd & MASK;
        end
        exp_q.push_back(model);
        #1;
        check({req, " R9 dsi_lock"}, {31'd0, dsi_lock_o}, {31'd0, (fl[3] | fl[2]) & viol});
        check({req, " R10/R11 vec_unavail"}, {31'd0, vec_unavail_o},
              {31'd0, (fl[1] | fl[0]) & ~msr[0]});
    endtask

    // flags: {ill,priv,trap,store,dlock,ilock,vechi,sfp}; msr: {user,ulock_en,vec_avail}
    initial begin
        repeat (3) @(posedge clk);
        #2 check("R1 reset", syn_o, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        drive("R2 illegal",   1, 0, 8'b1000_0000, 3'b001, 0, 0);
        drive("R2 priv+trap", 1, 0, 8'b0111_1100, 3'b101, 0, 0);
        drive("R3 align st",  1, 1, 8'b1001_1100, 3'b101, 0, 0);
        drive("R3 dtlb st",   1, 3, 8'b0001_0000, 3'b001, 0, 0);
        drive("R4 dsi dlock", 1, 2, 8'b0001_1000, 3'b101, 0, 0);
        drive("R5 dsi ilock", 1, 2, 8'b0000_0100, 3'b101, 0, 0);
        drive("R4 enabled",   1, 2, 8'b0000_1100, 3'b111, 0, 0);
        drive("R5 supervisor",1, 2, 8'b0000_1100, 3'b001, 0, 0);
        drive("R8 idle hold", 0, 0, 8'b1111_1100, 3'b101, 0, 0);
        drive("R6 write ones",0, 0, 8'b0, 3'b001, 1, 32'hFFFF_FFFF);
        drive("R8 hold",      0, 2, 8'b0, 3'b001, 0, 0);
        drive("R7 take wins", 1, 0, 8'b0010_0000, 3'b001, 1, 32'hFFFF_FFFF);
        drive("R8 write",     0, 0, 8'b0, 3'b001, 1, 32'h0A20_0001);
        drive("R7 overwrite", 1, 1, 8'b0000_0000, 3'b001, 0, 0);
        drive("R10 vechi",    0, 0, 8'b0000_0010, 3'b000, 0, 0);
        drive("R10 avail",    0, 0, 8'b0000_0010, 3'b001, 0, 0);
        drive("R11 scalar",   0, 0, 8'b0000_0001, 3'b000, 0, 0);
        drive("R11 avail",    0, 0, 8'b0000_0001, 3'b001, 0, 0);
        for (int i = 0; i < 32; i++)
            drive("R4/R5 sweep", 1, 2, {3'b0, 1'b1, i[4], i[3], i[2], 1'b0},
                  {i[1], i[0], 1'b1}, 0, 0);
        drive("R8 final", 0, 0, 8'b0, 3'b001, 0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_vec++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule